// File: doc/BRIEF.md
# Serial Potentiometer Command Front End

This block is the digital side of a serial-controlled potentiometer. A host talks to it in frames bounded by an active-low select line. Each frame begins with an identification byte. The block accepts the frame only when that byte carries the expected device type and the two strapped address bits. The second byte holds an opcode together with a register pointer and a bank pointer. What follows depends on the opcode: a data byte for a read or write, nothing more for a transfer, or an open-ended stream of step pulses for increment/decrement.

All serial pins are synchronised into the system clock domain. Transfers and stores therefore reach the neighbouring wiper block and register file as single-cycle request pulses, and read data is returned on a serial output with a separate output-enable. A pause input freezes the shifting part-way through a frame without losing its state.

Top module: `dpot_cmd_ctrl`

## Requirements
- R1: The first byte after select falls is accepted only if bits [7:4] are 0101, bits [3:2] are 00 and bits [1:0] equal `dev_addr`. On a mismatch the rest of the frame causes no request and leaves `so_oe` low.
- R2: The second byte is {opcode[3:0], reg[1:0], bank[1:0]}. Wiper read (1001), wiper write (1010), register-to-wiper transfer (1101) and wiper-to-register transfer (1110) act only when bank is 00. With any other bank they are ignored.
- R3: Read wiper (1001), read register (1011) and read status (0101) return 8 bits on `so`, most significant bit first. Each bit changes after a falling `sck` edge, the first after the falling edge that ends the second byte. Status reads return {7'b0, nv_busy}. The third byte on `si` is ignored.
- R4: A wiper write issues one `wip_ld_req` pulse carrying the third byte after its eighth bit. A register-to-wiper transfer issues one `wip_ld_req` pulse carrying the addressed bank-0 register value after the second byte.
- R5: After opcode 0010, every later rising `sck` issues one `wip_step_req` pulse, with `wip_step_up` equal to `si` (1 toward the high end, 0 toward the low end). This continues until select rises.
- R6: Register writes (1100, value from the third byte) and wiper-to-register transfers (1110, value from `wiper_val`) issue `rf_wr_req` only when select rises. The frame must hold exactly 24 or 16 clocks respectively; a truncated or over-long frame issues no write.
- R7: Taking `hold_n` low while `sck` is low pauses the frame: `sck` edges are ignored and `so_oe` is low. Taking it high while `sck` is low resumes the frame where it stopped.
- R8: While select is high, `so_oe` is low and the frame restarts. After reset, a high-to-low transition of select is required before any frame is accepted.
- R9: Opcodes not listed above issue no request and leave `so_oe` low for the whole frame.
- R10: `rf_addr` equals {bank, reg} taken from the second byte, for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low frame select |
| si | input | 1 | Serial data from host |
| hold_n | input | 1 | Active-low pause |
| dev_addr | input | 2 | Strapped device address |
| so | output | 1 | Serial read data |
| so_oe | output | 1 | Output enable for `so` (0 means high impedance) |
| wiper_val | input | 8 | Current wiper position |
| wip_ld_req | output | 1 | Wiper load request pulse |
| wip_ld_val | output | 8 | Value to load into the wiper |
| wip_step_req | output | 1 | Wiper single-step request pulse |
| wip_step_up | output | 1 | Step direction, 1 toward the high end |
| rf_addr | output | 4 | Register file address {bank, reg} |
| rf_rd_data | input | 8 | Register file read data at `rf_addr` |
| rf_wr_req | output | 1 | Register file store request pulse |
| rf_wr_data | output | 8 | Register file store value |
| nv_busy | input | 1 | Store-in-progress flag returned by status reads |

## Verification
The bench first holds select low through reset and then sends a well-formed wiper write. A design that treats reset as a select edge would move the wiper. Write frames are cut short and also given one extra clock, which catches a design that commits on the eighth data bit instead of on select rising, or that ignores overlong frames. Transfers and wiper commands are sent with a non-zero bank, which exposes a missing bank gate, and identification bytes each carry a single wrong field, which exposes partial address matching. A read is paused in the middle of its data byte while `sck` keeps toggling; a design that keeps shifting during the pause returns a corrupted byte.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
   localparam int unsigned BYTE_W  = 8;
   localparam int unsigned REG_W   = 2;
   localparam int unsigned BANK_W  = 2;
   localparam int unsigned RADDR_W = BANK_W + REG_W;
   localparam int unsigned CNT_W   = $clog2(BYTE_W);
   localparam logic [3:0]  DEV_TYPE = 4'b0101;

   typedef enum logic [3:0] {
      OP_STEP = 4'b0010,
      OP_STAT = 4'b0101,
      OP_RD_W = 4'b1001,
      OP_WR_W = 4'b1010,
      OP_RD_R = 4'b1011,
      OP_WR_R = 4'b1100,
      OP_R2W  = 4'b1101,
      OP_W2R  = 4'b1110
   } opcode_e;

   typedef enum logic [2:0] {
      FS_IDLE, FS_ID, FS_INS, FS_EXEC, FS_DATA, FS_STEP, FS_SINK
   } fstate_e;
endpackage

// File: rtl/dpot_pin_sync.sv
module dpot_pin_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= {STAGES{RST_VAL}};
      else        q <= {q[STAGES-2:0], din};
   end

   assign dout = q[STAGES-1];
endmodule

// File: rtl/dpot_out_shift.sv
module dpot_out_shift #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift,
   output logic         so
);
   logic [W-1:0] osh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         osh <= '0;
         so  <= 1'b0;
      end else if (load) begin
         osh <= load_val;
      end else if (shift) begin
         so  <= osh[W-1];
         osh <= {osh[W-2:0], 1'b0};
      end
   end
endmodule

// File: rtl/dpot_frame_fsm.sv
module dpot_frame_fsm
   import dpot_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_s,
   input  logic               cs_fall,
   input  logic               cs_rise,
   input  logic               sck_rise,
   input  logic               si_s,
   input  logic [1:0]         dev_addr,
   input  logic [BYTE_W-1:0]  wiper_val,
   input  logic [BYTE_W-1:0]  rf_rd_data,
   input  logic               nv_busy,
   output logic               rd_load,
   output logic [BYTE_W-1:0]  rd_val,
   output logic               rd_mode,
   output logic               wip_ld_req,
   output logic [BYTE_W-1:0]  wip_ld_val,
   output logic               wip_step_req,
   output logic               wip_step_up,
   output logic [RADDR_W-1:0] rf_addr,
   output logic               rf_wr_req,
   output logic [BYTE_W-1:0]  rf_wr_data
);
   fstate_e           st;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-2:0] sh;
   logic [3:0]        op;
   logic              pend;
   logic [BYTE_W-1:0] byte_in;
   logic              last_bit;
   logic              bank0;

   assign byte_in  = {sh, si_s};
   assign last_bit = sck_rise && (cnt == CNT_W'(BYTE_W - 1));
   assign bank0    = (rf_addr[RADDR_W-1 -: BANK_W] == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= FS_IDLE; cnt <= '0; sh <= '0; op <= '0; pend <= 1'b0;
         rd_load <= 1'b0; rd_val <= '0; rd_mode <= 1'b0;
         wip_ld_req <= 1'b0; wip_ld_val <= '0;
         wip_step_req <= 1'b0; wip_step_up <= 1'b0;
         rf_addr <= '0; rf_wr_req <= 1'b0; rf_wr_data <= '0;
      end else begin
         rd_load      <= 1'b0;
         wip_ld_req   <= 1'b0;
         wip_step_req <= 1'b0;
         rf_wr_req    <= 1'b0;
         if (cs_rise) begin
            rf_wr_req <= pend;
            pend      <= 1'b0;
         end
         if (cs_s) begin
            st      <= FS_IDLE;
            cnt     <= '0;
            rd_mode <= 1'b0;
         end else if (cs_fall) begin
            st  <= FS_ID;
            cnt <= '0;
         end else begin
            if ((st == FS_ID || st == FS_INS || st == FS_DATA) && sck_rise) begin
               sh  <= byte_in[BYTE_W-2:0];
               cnt <= cnt + CNT_W'(1);
            end
            unique case (st)
               FS_ID: if (last_bit) begin
                  if (byte_in[7:4] == DEV_TYPE && byte_in[3:2] == 2'b00 &&
                      byte_in[1:0] == dev_addr) st <= FS_INS;
                  else                            st <= FS_SINK;
               end
               FS_INS: if (last_bit) begin
                  op      <= byte_in[7:4];
                  rf_addr <= {byte_in[BANK_W-1:0], byte_in[BANK_W +: REG_W]};
                  st      <= FS_EXEC;
               end
               FS_EXEC: begin
                  st <= FS_SINK;
                  case (op)
                     OP_RD_W: if (bank0) begin
                        rd_load <= 1'b1; rd_val <= wiper_val; rd_mode <= 1'b1; st <= FS_DATA;
                     end
                     OP_WR_W: if (bank0) st <= FS_DATA;
                     OP_RD_R: begin
                        rd_load <= 1'b1; rd_val <= rf_rd_data; rd_mode <= 1'b1; st <= FS_DATA;
                     end
                     OP_WR_R: st <= FS_DATA;
                     OP_STAT: begin
                        rd_load <= 1'b1; rd_val <= {{(BYTE_W-1){1'b0}}, nv_busy};
                        rd_mode <= 1'b1; st <= FS_DATA;
                     end
                     OP_R2W: if (bank0) begin
                        wip_ld_req <= 1'b1; wip_ld_val <= rf_rd_data;
                     end
                     OP_W2R: if (bank0) begin
                        pend <= 1'b1; rf_wr_data <= wiper_val;
                     end
                     OP_STEP: st <= FS_STEP;
                     default: st <= FS_SINK;
                  endcase
               end
               FS_DATA: if (last_bit) begin
                  if (op == OP_WR_W) begin
                     wip_ld_req <= 1'b1; wip_ld_val <= byte_in;
                  end
                  if (op == OP_WR_R) begin
                     pend <= 1'b1; rf_wr_data <= byte_in;
                  end
                  st <= FS_SINK;
               end
               FS_STEP: if (sck_rise) begin
                  wip_step_req <= 1'b1;
                  wip_step_up  <= si_s;
               end
               FS_SINK: if (sck_rise) pend <= 1'b0;
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/dpot_cmd_ctrl.sv
module dpot_cmd_ctrl
   import dpot_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sck,
   input  logic               cs_n,
   input  logic               si,
   input  logic               hold_n,
   input  logic [1:0]         dev_addr,
   output logic               so,
   output logic               so_oe,
   input  logic [BYTE_W-1:0]  wiper_val,
   output logic               wip_ld_req,
   output logic [BYTE_W-1:0]  wip_ld_val,
   output logic               wip_step_req,
   output logic               wip_step_up,
   output logic [RADDR_W-1:0] rf_addr,
   input  logic [BYTE_W-1:0]  rf_rd_data,
   output logic               rf_wr_req,
   output logic [BYTE_W-1:0]  rf_wr_data,
   input  logic               nv_busy
);
   localparam int unsigned NPIN    = 4;
   localparam logic [NPIN-1:0] PIN_RST = 4'b1000;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("dpot_cmd_ctrl: SYNC_STAGES must be at least 2");
   end

   logic [NPIN-1:0] pin_raw, pin_s;
   logic sck_s, cs_s, si_s, hold_s;
   logic sck_d, cs_d, paused;
   logic sck_rise, sck_fall, cs_rise, cs_fall;
   logic rd_load, rd_mode;
   logic [BYTE_W-1:0] rd_val;

   assign pin_raw = {hold_n, si, cs_n, sck};

   for (genvar g = 0; g < NPIN; g++) begin : g_sync
      dpot_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(PIN_RST[g])) u_sync (
         .clk(clk), .rst_n(rst_n), .din(pin_raw[g]), .dout(pin_s[g]));
   end

   assign {hold_s, si_s, cs_s, sck_s} = pin_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d  <= 1'b0;
         cs_d   <= 1'b0;
         paused <= 1'b0;
      end else begin
         sck_d <= sck_s;
         cs_d  <= cs_s;
         if (cs_s)        paused <= 1'b0;
         else if (!sck_s) paused <= !hold_s;
      end
   end

   assign sck_rise = sck_s & ~sck_d & ~paused & ~cs_s;
   assign sck_fall = ~sck_s & sck_d & ~paused & ~cs_s;
   assign cs_rise  = cs_s & ~cs_d;
   assign cs_fall  = ~cs_s & cs_d;

   dpot_frame_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .cs_fall(cs_fall), .cs_rise(cs_rise),
      .sck_rise(sck_rise), .si_s(si_s), .dev_addr(dev_addr),
      .wiper_val(wiper_val), .rf_rd_data(rf_rd_data), .nv_busy(nv_busy),
      .rd_load(rd_load), .rd_val(rd_val), .rd_mode(rd_mode),
      .wip_ld_req(wip_ld_req), .wip_ld_val(wip_ld_val),
      .wip_step_req(wip_step_req), .wip_step_up(wip_step_up),
      .rf_addr(rf_addr), .rf_wr_req(rf_wr_req), .rf_wr_data(rf_wr_data));

   dpot_out_shift #(.W(BYTE_W)) u_oshift (
      .clk(clk), .rst_n(rst_n), .load(rd_load), .load_val(rd_val),
      .shift(sck_fall & rd_mode), .so(so));

   assign so_oe = rd_mode & ~cs_s & ~paused;
endmodule

// File: rtl/dpot_cmd_ctrl_chk.sv
module dpot_cmd_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic cs_s,
   input logic paused,
   input logic sck_rise,
   input logic so_oe,
   input logic wip_ld_req,
   input logic wip_step_req,
   input logic rf_wr_req
);
   assert_so_hiz_deselect_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |-> !so_oe);

   assert_so_hiz_paused_R7: assert property (@(posedge clk) disable iff (!rst_n)
      paused |-> !so_oe);

   assert_store_on_select_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rf_wr_req |-> ($past(cs_s) && !$past(cs_s, 2)));

   assert_step_follows_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wip_step_req |-> $past(sck_rise));

   assert_single_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wip_ld_req, wip_step_req, rf_wr_req}));

   assert_load_is_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wip_ld_req |=> !wip_ld_req);
endmodule

bind dpot_cmd_ctrl dpot_cmd_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .paused(paused), .sck_rise(sck_rise),
   .so_oe(so_oe), .wip_ld_req(wip_ld_req), .wip_step_req(wip_step_req),
   .rf_wr_req(rf_wr_req));

// File: tb/dpot_cmd_ctrl_tb_top.sv
module dpot_cmd_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;
   localparam logic [1:0] ADDR = 2'b10;
   localparam logic [7:0] ID_OK = {4'b0101, 2'b00, ADDR};

   typedef struct packed {
      logic [7:0] ins;
      logic [7:0] dat;
      logic       three;
      logic [1:0] kind;
      logic [7:0] exp;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{8'hA0, 8'h5A, 1'b1, 2'd2, 8'h5A},
      '{8'h90, 8'h00, 1'b1, 2'd1, 8'h5A},
      '{8'hC6, 8'h3C, 1'b1, 2'd3, 8'h3C},
      '{8'hB6, 8'hFF, 1'b1, 2'd1, 8'h3C},
      '{8'hEC, 8'h00, 1'b0, 2'd3, 8'h5A},
      '{8'hA0, 8'h11, 1'b1, 2'd2, 8'h11},
      '{8'hDC, 8'h00, 1'b0, 2'd2, 8'h5A},
      '{8'h50, 8'h00, 1'b1, 2'd1, 8'h00},
      '{8'hA1, 8'h77, 1'b1, 2'd2, 8'h5A},
      '{8'h30, 8'h00, 1'b1, 2'd2, 8'h5A},
      '{8'hBB, 8'h00, 1'b1, 2'd1, 8'h4E}
   };

   logic clk = 1'b0;
   logic rst_n, sck, cs_n, si, hold_n, nv_busy;
   logic so, so_oe, wip_ld_req, wip_step_req, wip_step_up, rf_wr_req;
   logic [7:0] wip_ld_val, rf_wr_data, rf_rd_data;
   logic [3:0] rf_addr;
   logic [7:0] wiper_m;
   logic [7:0] mem_m [16];
   int n_ld, n_step, n_wr;
   int nchk = 0, nfail = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dpot_cmd_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
      .dev_addr(ADDR), .so(so), .so_oe(so_oe), .wiper_val(wiper_m),
      .wip_ld_req(wip_ld_req), .wip_ld_val(wip_ld_val),
      .wip_step_req(wip_step_req), .wip_step_up(wip_step_up),
      .rf_addr(rf_addr), .rf_rd_data(rf_rd_data), .rf_wr_req(rf_wr_req),
      .rf_wr_data(rf_wr_data), .nv_busy(nv_busy));

   assign rf_rd_data = mem_m[rf_addr];

   // Models of the wiper block and register file around the controller
   always @(posedge clk) begin
      if (!rst_n) begin
         wiper_m <= 8'h80;
         for (int i = 0; i < 16; i++) mem_m[i] <= 8'h40 + 8'(i);
         n_ld <= 0; n_step <= 0; n_wr <= 0;
      end else begin
         if (wip_ld_req) begin
            wiper_m <= wip_ld_val; n_ld <= n_ld + 1;
         end else if (wip_step_req) begin
            n_step <= n_step + 1;
            if (wip_step_up && wiper_m != 8'hFF) wiper_m <= wiper_m + 8'd1;
            if (!wip_step_up && wiper_m != 8'h00) wiper_m <= wiper_m - 8'd1;
         end
         if (rf_wr_req) begin
            mem_m[rf_addr] <= rf_wr_data; n_wr <= n_wr + 1;
         end
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic spi_bit(input logic b, output logic r);
      si = b;
      wait_clk(HALF);
      r = so;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
   endtask

   task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) spi_bit(tx[i], rx[i]);
   endtask

   task automatic sel();
      cs_n = 1'b0; wait_clk(HALF);
   endtask

   task automatic desel();
      wait_clk(HALF); cs_n = 1'b1; wait_clk(3*HALF);
   endtask

   task automatic frame(input logic [7:0] id, input logic [7:0] ins,
                        input logic [7:0] dat, input logic three, output logic [7:0] rx);
      logic [7:0] r;
      sel();
      spi_byte(id, r);
      spi_byte(ins, r);
      rx = 8'h00;
      if (three) spi_byte(dat, rx);
      desel();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL R8 watchdog expired actual=hung expected=done");
      finish_run();
   end

   initial begin
      logic [7:0] rx;
      logic r;
      int base;
      rst_n = 1'b0; sck = 1'b0; cs_n = 1'b0; si = 1'b0; hold_n = 1'b1; nv_busy = 1'b0;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(4);
      check("R8 reset so_oe", so_oe, 0);
      check("R8 reset wiper", wiper_m, 8'h80);

      // R8: select already low at reset; no falling edge, frame must be ignored
      spi_byte(ID_OK, rx); spi_byte(8'hA0, rx); spi_byte(8'h33, rx);
      desel();
      check("R8 no frame without select edge", n_ld, 0);
      check("R8 wiper unchanged", wiper_m, 8'h80);

      for (int v = 0; v < NV; v++) begin
         frame(ID_OK, VECS[v].ins, VECS[v].dat, VECS[v].three, rx);
         case (VECS[v].kind)
            2'd1: check($sformatf("R3 read vec%0d", v), rx, VECS[v].exp);
            2'd2: check($sformatf("R4 wiper vec%0d", v), wiper_m, VECS[v].exp);
            2'd3: check($sformatf("R6 store vec%0d", v),
                        mem_m[{VECS[v].ins[1:0], VECS[v].ins[3:2]}], VECS[v].exp);
            default: ;
         endcase
      end

      // R1: one wrong field in the identification byte
      base = n_ld;
      frame(8'h72, 8'hA0, 8'h01, 1'b1, rx);
      frame(8'h51, 8'hA0, 8'h02, 1'b1, rx);
      frame(8'h5E, 8'hA0, 8'h03, 1'b1, rx);
      check("R1 bad id no load", n_ld - base, 0);
      check("R1 bad id wiper", wiper_m, 8'h5A);

      // R2: transfer with non-zero bank ignored
      base = n_ld;
      frame(ID_OK, 8'hD5, 8'h00, 1'b0, rx);
      check("R2 bank gate transfer", n_ld - base, 0);

      // R9: reserved opcode keeps SO off through its frame
      sel(); spi_byte(ID_OK, rx); spi_byte(8'h70, rx);
      wait_clk(2);
      check("R9 reserved so_oe", so_oe, 0);
      spi_byte(8'h00, rx); desel();

      // R3: output enabled during a valid read, off when deselected
      sel(); spi_byte(ID_OK, rx); spi_byte(8'h90, rx);
      wait_clk(2);
      check("R3 read so_oe", so_oe, 1);
      spi_byte(8'h00, rx); desel();
      check("R8 deselected so_oe", so_oe, 0);

      // R10: register write to bank 1 reg 2 lands at address 6
      frame(ID_OK, 8'hC9, 8'h99, 1'b1, rx);
      check("R10 address {bank,reg}", mem_m[6], 8'h99);

      // R5: increment/decrement stream
      base = n_step;
      sel(); spi_byte(ID_OK, rx); spi_byte(8'h20, rx);
      spi_bit(1'b1, r); spi_bit(1'b1, r); spi_bit(1'b1, r); spi_bit(1'b0, r);
      desel();
      check("R5 step count", n_step - base, 4);
      check("R5 wiper after steps", wiper_m, 8'h5C);

      // R6: truncated and over-long write frames do not store
      base = n_wr;
      sel(); spi_byte(ID_OK, rx); spi_byte(8'hC0, rx);
      for (int i = 0; i < 4; i++) spi_bit(1'b1, r);
      desel();
      sel(); spi_byte(ID_OK, rx); spi_byte(8'hC0, rx); spi_byte(8'h12, rx); spi_bit(1'b0, r);
      desel();
      sel(); spi_byte(ID_OK, rx); spi_byte(8'hE4, rx); spi_bit(1'b0, r);
      desel();
      check("R6 malformed frames no store", n_wr - base, 0);
      check("R6 reg0 untouched", mem_m[0], 8'h40);
      frame(ID_OK, 8'hC0, 8'h12, 1'b1, rx);
      check("R6 exact frame stores", mem_m[0], 8'h12);

      // R7: pause in the middle of a read data byte
      sel(); spi_byte(ID_OK, rx); spi_byte(8'h90, rx);
      for (int i = 7; i >= 0; i--) begin
         if (i == 3) begin
            hold_n = 1'b0; wait_clk(HALF);
            sck = 1'b1; wait_clk(HALF); sck = 1'b0; wait_clk(HALF);
            sck = 1'b1; wait_clk(HALF); sck = 1'b0; wait_clk(2);
            check("R7 paused so_oe", so_oe, 0);
            hold_n = 1'b1; wait_clk(HALF);
         end
         spi_bit(1'b0, rx[i]);
      end
      desel();
      check("R7 read after pause", rx, 8'h5C);

      // R3: status bit reflects nv_busy
      nv_busy = 1'b1;
      frame(ID_OK, 8'h50, 8'h00, 1'b1, rx);
      check("R3 status busy", rx, 8'h01);
      nv_busy = 1'b0;

      finish_run();
   end
endmodule